// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog with one 8-bit divider that it shares with a general-purpose timer. The watchdog counts ticks from its own free-running oscillator, which is independent of the system clock. Those ticks are synchronised into the system clock domain and edge-detected before any logic uses them. A base counter overflows after `BASE_TICKS` ticks. An option register picks the owner of the divider:

- With the assignment bit set, the divider belongs to the watchdog. It acts as a postscaler on the base overflow, with a ratio of 1:1 to 1:128.
- With the assignment bit clear, the divider belongs to the timer. It acts as a prescaler on the timer clock source, and the watchdog times out on every base overflow.

The effect of a time-out depends on the sleep-mode flag:

- When the device is awake, a time-out raises a one-cycle reset request.
- When the device is asleep, a time-out raises a one-cycle wake-up request instead.

A configuration enable held low stops the watchdog for good. Software strobes a clear input to restart the count. The sleep strobe restarts the count in the same way. A status flag reads 0 after a watchdog time-out, so software can tell that cause apart from other resets.

In the bench model the system clock keeps running during sleep. The synchroniser needs it, and the sleep state is seen only through `sleep_mode`.

Top module: `wdog_divshare`

## Requirements
- R1: After reset, `to_flag` is 1 and both `rst_req` and `wake_req` are 0. The option register reads all ones after reset, so the divider belongs to the watchdog at ratio 1:128. The first time-out then comes after `BASE_TICKS*128` oscillator ticks.
- R2: When `opt_assign` is 1 and the ratio field is r, a time-out happens every `BASE_TICKS*2^r` ticks. A time-out with `sleep_mode` at 0 pulses `rst_req` high for exactly one cycle.
- R3: A time-out with `sleep_mode` at 1 pulses `wake_req` for one cycle, and `rst_req` stays 0.
- R4: While `cfg_wdt_en` is 0 the watchdog never times out, and its count is held at zero.
- R5: Pulsing `clr_wdt` or `sleep_cmd` restarts the base count. When the divider belongs to the watchdog, the same pulse also restarts the divider, so the next time-out needs a full period of ticks.
- R6: A time-out clears `to_flag` to 0. A `clr_wdt` or `sleep_cmd` pulse sets it back to 1.
- R7: When `opt_assign` is 0, the watchdog times out every `BASE_TICKS` ticks whatever the ratio field holds. In the same mode, `tmr_tick` pulses once per `2^(r+1)` `tmr_src` pulses.
- R8: When `opt_assign` is 1, `tmr_tick` repeats every `tmr_src` pulse one cycle later (ratio 1:1).
- R9: Each rising edge of `wdt_osc` counts as one tick, however long the oscillator stays high.
- R10: A one-cycle `opt_wr` loads `opt_wdata`. Bit 3 is the assignment (1 means watchdog) and bits 2:0 are the ratio r. A write that changes the assignment restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wdt_osc | input | 1 | Free-running watchdog oscillator, asynchronous |
| tmr_src | input | 1 | Timer clock source, one-cycle pulses in the `clk` domain |
| cfg_wdt_en | input | 1 | Configuration enable for the watchdog |
| opt_wr | input | 1 | Strobe that loads the option register |
| opt_wdata | input | 4 | Option value: bit 3 is the assignment, bits 2:0 are the ratio |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep strobe, clears the watchdog the same way |
| sleep_mode | input | 1 | High while the device sleeps |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| tmr_tick | output | 1 | Prescaled timer clock pulse |
| to_flag | output | 1 | Time-out status flag, 0 after a watchdog time-out |

## Verification
The bench applies tick counts that fall one short of a period and that land exactly on it, for several ratios. A divider tap chosen one position off, or a divider that keeps running in timer mode, therefore changes the number of reset pulses it sees. It clears the watchdog in the middle of a count and then expects a full new period. A clear that left the divider running would time out early. It holds the oscillator high for many cycles, which a level-sensitive tick path would count more than once. It also checks that a sleeping time-out produces a wake-up and no reset, and that a disabled watchdog stays quiet through many periods.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RATIO_W = 3;

  typedef struct packed {
    logic               to_wdt;
    logic [RATIO_W-1:0] ratio;
  } wdog_opt_t;

  localparam wdog_opt_t OPT_RESET = '{to_wdt: 1'b1, ratio: '1};
endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic tick
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= osc_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign tick = chain[STAGES-1] & ~last;

  // R9: one tick per rising edge, never two cycles in a row
  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdog_base_cnt.sv
module wdog_base_cnt #(
  parameter int BASE_TICKS = 18,
  localparam int CW = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic ovf
);
  localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);
  logic [CW-1:0] cnt;

  assign ovf = en & tick & ~clr & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || clr)   cnt <= '0;
    else if (tick)         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0) && !ovf);
  assert_clear_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/wdog_option_reg.sv
module wdog_option_reg
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  wdog_opt_t wdata,
  output wdog_opt_t opt,
  output logic      swap
);
  assign swap = wr & (wdata.to_wdt != opt.to_wdt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  opt <= OPT_RESET;
    else if (wr) opt <= wdata;
  end

  assert_opt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(opt));
endmodule

// File: rtl/wdog_shared_div.sv
module wdog_shared_div
  import wdog_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  wdog_opt_t opt,
  input  logic      swap,
  input  logic      clr,
  input  logic      base_ovf,
  input  logic      tmr_src,
  output logic      wdt_to,
  output logic      tmr_tick
);
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] wdt_mask;
  logic [DIV_W-1:0] tmr_mask;
  logic             div_step;
  logic             wdt_hit;
  logic             tmr_hit;

  assign wdt_mask = (DIV_W'(1) << opt.ratio) - DIV_W'(1);
  assign tmr_mask = (DIV_W'(2) << opt.ratio) - DIV_W'(1);
  assign wdt_hit  = &(div | ~wdt_mask);
  assign tmr_hit  = &(div | ~tmr_mask);
  assign div_step = opt.to_wdt ? base_ovf : tmr_src;
  assign wdt_to   = opt.to_wdt ? (base_ovf & wdt_hit) : base_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     div <= '0;
    else if (swap)                  div <= '0;
    else if (clr && opt.to_wdt)     div <= '0;
    else if (div_step)              div <= div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_tick <= 1'b0;
    else        tmr_tick <= opt.to_wdt ? tmr_src : (tmr_src & tmr_hit);
  end

  assert_bypass_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opt.to_wdt && tmr_src) |=> tmr_tick);
  assert_tmr_needs_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_src |=> !tmr_tick);
endmodule

// File: rtl/wdog_divshare.sv
module wdog_divshare
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS  = 18,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_osc,
  input  logic       tmr_src,
  input  logic       cfg_wdt_en,
  input  logic       opt_wr,
  input  logic [3:0] opt_wdata,
  input  logic       clr_wdt,
  input  logic       sleep_cmd,
  input  logic       sleep_mode,
  output logic       rst_req,
  output logic       wake_req,
  output logic       tmr_tick,
  output logic       to_flag
);
  logic      tick;
  logic      clr;
  logic      base_ovf;
  logic      timeout;
  logic      swap;
  wdog_opt_t opt;

  assign clr = clr_wdt | sleep_cmd;

  wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .osc_in(wdt_osc), .tick(tick));

  wdog_base_cnt #(.BASE_TICKS(BASE_TICKS)) u_base (
    .clk(clk), .rst_n(rst_n), .en(cfg_wdt_en), .tick(tick),
    .clr(clr), .ovf(base_ovf));

  wdog_option_reg u_opt (
    .clk(clk), .rst_n(rst_n), .wr(opt_wr), .wdata(wdog_opt_t'(opt_wdata)),
    .opt(opt), .swap(swap));

  wdog_shared_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .opt(opt), .swap(swap), .clr(clr),
    .base_ovf(base_ovf), .tmr_src(tmr_src), .wdt_to(timeout),
    .tmr_tick(tmr_tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b1;
    end else begin
      rst_req  <= timeout & ~sleep_mode;
      wake_req <= timeout & sleep_mode;
      if (timeout)  to_flag <= 1'b0;
      else if (clr) to_flag <= 1'b1;
    end
  end

  assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));
  assert_rst_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_wake_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  assert_flag_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> !to_flag);
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> to_flag);
endmodule

// File: tb/wdog_divshare_test.sv
module wdog_divshare_test;
  localparam int BT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_osc = 1'b0, tmr_src = 1'b0, cfg_wdt_en = 1'b1, opt_wr = 1'b0;
  logic [3:0] opt_wdata = 4'h0;
  logic clr_wdt = 1'b0, sleep_cmd = 1'b0, sleep_mode = 1'b0;
  logic rst_req, wake_req, tmr_tick, to_flag;

  int checks = 0, fails = 0;
  int rst_cnt = 0, wake_cnt = 0, tmr_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_divshare #(.BASE_TICKS(BT)) uut (
    .clk(clk), .rst_n(rst_n), .wdt_osc(wdt_osc), .tmr_src(tmr_src),
    .cfg_wdt_en(cfg_wdt_en), .opt_wr(opt_wr), .opt_wdata(opt_wdata),
    .clr_wdt(clr_wdt), .sleep_cmd(sleep_cmd), .sleep_mode(sleep_mode),
    .rst_req(rst_req), .wake_req(wake_req), .tmr_tick(tmr_tick),
    .to_flag(to_flag));

  // counts high cycles, so a stretched pulse shows as extra counts
  always @(negedge clk) begin
    if (rst_n) begin
      rst_cnt  <= rst_cnt + int'(rst_req);
      wake_cnt <= wake_cnt + int'(wake_req);
      tmr_cnt  <= tmr_cnt + int'(tmr_tick);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n, int high = 3);
    for (int i = 0; i < n; i++) begin
      wdt_osc = 1'b1; repeat (high) @(negedge clk);
      wdt_osc = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe_clr(bit use_sleep);
    @(negedge clk);
    if (use_sleep) sleep_cmd = 1'b1; else clr_wdt = 1'b1;
    @(negedge clk);
    sleep_cmd = 1'b0; clr_wdt = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_opt(logic [3:0] v);
    @(negedge clk);
    opt_wdata = v; opt_wr = 1'b1;
    @(negedge clk);
    opt_wr = 1'b0;
  endtask

  task automatic tmr_pulses(int n);
    for (int i = 0; i < n; i++) begin
      tmr_src = 1'b1; @(negedge clk);
      tmr_src = 1'b0; @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic zero_counts;
    rst_cnt = 0; wake_cnt = 0; tmr_cnt = 0;
  endtask

  // {assign, ratio, ticks applied, expected reset pulses}
  typedef struct packed { logic a; logic [2:0] r; logic [15:0] n; logic [7:0] e; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b1, 3'd0, 16'd6,  8'd1},
    '{1'b1, 3'd0, 16'd17, 8'd2},
    '{1'b1, 3'd1, 16'd11, 8'd0},
    '{1'b1, 3'd1, 16'd12, 8'd1},
    '{1'b1, 3'd2, 16'd47, 8'd1},
    '{1'b1, 3'd3, 16'd48, 8'd1},
    '{1'b0, 3'd5, 16'd18, 8'd3},
    '{1'b0, 3'd7, 16'd5,  8'd0}
  };

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 to_flag after reset", int'(to_flag), 1);
    check("R1 rst_req after reset", int'(rst_req), 0);
    check("R1 wake_req after reset", int'(wake_req), 0);

    // R1: option reset value is watchdog at 1:128
    zero_counts();
    ticks(BT*128 - 1);
    check("R1 no time-out before 128 periods", rst_cnt, 0);
    ticks(1);
    check("R1 time-out at 128 periods", rst_cnt, 1);
    check("R6 to_flag cleared by time-out", int'(to_flag), 0);
    strobe_clr(1'b0);
    check("R6 to_flag set by clear", int'(to_flag), 1);

    // vector table for R2 and R7
    foreach (VECS[k]) begin
      write_opt({VECS[k].a, VECS[k].r});
      strobe_clr(1'b0);
      zero_counts();
      ticks(int'(VECS[k].n));
      check(VECS[k].a ? "R2 reset pulses" : "R7 reset pulses", rst_cnt, int'(VECS[k].e));
      check("R6 to_flag after vector", int'(to_flag), (VECS[k].e != 0) ? 0 : 1);
    end

    // R3: sleeping time-out wakes
    write_opt(4'b1_000);
    strobe_clr(1'b1);
    sleep_mode = 1'b1;
    zero_counts();
    ticks(BT);
    check("R3 wake pulses", wake_cnt, 1);
    check("R3 no reset in sleep", rst_cnt, 0);
    sleep_mode = 1'b0;

    // R4: disabled watchdog stays quiet
    cfg_wdt_en = 1'b0;
    strobe_clr(1'b0);
    zero_counts();
    ticks(BT*5);
    check("R4 disabled no reset", rst_cnt, 0);
    check("R4 disabled flag kept", int'(to_flag), 1);
    cfg_wdt_en = 1'b1;

    // R5: clear mid-count restarts base and divider
    write_opt(4'b1_001);
    strobe_clr(1'b0);
    zero_counts();
    ticks(BT + 3);
    strobe_clr(1'b0);
    ticks(2*BT - 1);
    check("R5 clear restarts period", rst_cnt, 0);
    ticks(1);
    check("R5 full period after clear", rst_cnt, 1);
    zero_counts();
    strobe_clr(1'b0);
    ticks(BT + 2);
    strobe_clr(1'b1);
    ticks(2*BT - 1);
    check("R5 sleep strobe restarts period", rst_cnt, 0);

    // R9: long high phase counts once
    write_opt(4'b1_000);
    strobe_clr(1'b0);
    zero_counts();
    ticks(BT - 1);
    ticks(1, 20);
    check("R9 long high is one tick", rst_cnt, 1);

    // R7/R10: timer prescaler 1:4 after assignment change
    write_opt(4'b0_001);
    zero_counts();
    tmr_pulses(8);
    check("R7 timer prescale 1:4", tmr_cnt, 2);
    write_opt(4'b0_000);
    zero_counts();
    tmr_pulses(5);
    check("R7 timer prescale 1:2 odd count", tmr_cnt, 2);

    // R8: bypass when divider belongs to watchdog
    write_opt(4'b1_011);
    zero_counts();
    tmr_pulses(3);
    check("R8 timer bypass 1:1", tmr_cnt, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule